// File: doc/BRIEF.md
# Fault Retry and Soft-Start Sequencer

This block decides when a push-pull primary-side controller may switch. Time is counted in oscillator cycles, not in clock ticks, so both the retry wait and the soft-start ramp stretch or shrink with the switching frequency. The oscillator arrives as a digital phase flag: high while the timing capacitor discharges (the dead time) and low while it charges (the interval in which an output pulse may occur). A supply-healthy flag and an overcurrent flag also come in as digital levels, already compared and filtered elsewhere.

Two permissions come out. `syncEnable` lets the synchronisation pulse run. `pulseGate` lets an output pulse start. During the soft-start ramp, `pulseGate` opens late inside the charge phase, so the pulse is cut at its leading edge. A fault removes both permissions in the same clock. The block then waits out a fixed hold-off, lets synchronisation run alone for one oscillator cycle, and widens the output pulses over seven ramp cycles until they reach full width.

A "cycle boundary" below means a clock edge at which `oscDischarge` is sampled high after being sampled low on the previous edge.

Top module: `softstart_seq`

## Requirements
- R1: While `overCurrent` is high, `syncEnable` and `pulseGate` are both low in that same clock, and the sequence restarts its hold-off.
- R2: While `supplyOk` is low, both outputs are low and the sequence is parked off. A return of `supplyOk` starts the full hold-off, sync-only and ramp sequence again.
- R3: Once the supply is healthy and no overcurrent is present, `syncEnable` stays low until 57 cycle boundaries have passed, so at least 56 whole oscillator cycles elapse. It rises in the clock after the 57th boundary.
- R4: After `syncEnable` rises, `pulseGate` stays low for exactly one oscillator cycle. It may first go high in the charge phase that follows the next cycle boundary.
- R5: Ramp step k (k = 1 to 7) lasts one oscillator cycle, and the step advances at each cycle boundary. In step k, `pulseGate` is low during discharge. During charge, it is high from charge tick floor(L*(8-k)/8) onward, where ticks are counted from 0 at the first charge clock and L is the measured charge length.
- R6: At the cycle boundary that ends step 7, the 8th boundary after `syncEnable` rose, `pulseGate` goes high and stays high in every clock, charge or discharge, until a fault.
- R7: L is the number of clocks in which `oscDischarge` was sampled low since the previous discharge phase. It is captured at each cycle boundary and saturates at 2^CNT_W-1.
- R8: During and immediately after reset, both outputs are low.
- R9: An overcurrent during the hold-off clears the hold-off count, so a full 57 boundaries are needed again after it clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| oscDischarge | input | 1 | Oscillator phase: 1 = discharge (dead time), 0 = charge |
| supplyOk | input | 1 | 1 = supply above its undervoltage threshold |
| overCurrent | input | 1 | 1 = current-sense threshold exceeded |
| syncEnable | output | 1 | Permission for the synchronisation pulse |
| pulseGate | output | 1 | Permission for an output pulse to start |

## Verification
The bound checker checks four things on every clock:
- Both outputs are killed under overcurrent or undervoltage.
- `pulseGate` never goes high without `syncEnable`.
- `syncEnable` never rises before more than 56 fault-free cycle boundaries have been counted.
- `pulseGate` never rises in the sync-only cycle.

The bench's scenarios are needed for the rest:
- The exact boundary counts of the hold-off, the sync lead and the ramp length.
- The leading-edge position of each ramp pulse against the charge length measured on the previous cycle, including when the oscillator period changes.
- The restart after an overcurrent that strikes during the hold-off.

// File: rtl/softstart_pkg.sv
package softstart_pkg;

  // Width of the ramp step index; RAMP_STEPS must fit below 2**STEP_W.
  parameter int STEP_W = 4;

  typedef enum logic [2:0] {
    SEQ_OFF,
    SEQ_HOLD,
    SEQ_SYNC,
    SEQ_RAMP,
    SEQ_RUN
  } seqState_e;

  // Strobes from the control FSM to the timing datapath.
  typedef struct packed {
    logic              holdClr;
    logic              holdInc;
    logic              rampOn;
    logic              runOn;
    logic [STEP_W-1:0] rampStep;
  } seqStrobe_t;

endpackage

// File: rtl/softstart_ctrl.sv
module softstart_ctrl
  import softstart_pkg::*;
#(
  parameter int RAMP_STEPS = 7
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyOk,
  input  logic       overCurrent,
  input  logic       cycleTick,
  input  logic       holdDone,
  output seqStrobe_t strobe,
  output logic       syncOn
);

  localparam logic [STEP_W-1:0] LAST_STEP  = STEP_W'(RAMP_STEPS);
  localparam logic [STEP_W-1:0] FIRST_STEP = STEP_W'(1);

  seqState_e         state, nextState;
  logic [STEP_W-1:0] rampStep, nextStep;
  logic              holdClr, holdInc;

  always_comb begin
    nextState = state;
    nextStep  = rampStep;
    holdClr   = 1'b0;
    holdInc   = 1'b0;
    if (!supplyOk) begin
      nextState = SEQ_OFF;
      nextStep  = '0;
      holdClr   = 1'b1;
    end else if (overCurrent) begin
      nextState = SEQ_HOLD;
      nextStep  = '0;
      holdClr   = 1'b1;
    end else begin
      unique case (state)
        SEQ_OFF: begin
          nextState = SEQ_HOLD;
          holdClr   = 1'b1;
        end
        SEQ_HOLD: begin
          if (cycleTick) begin
            if (holdDone) nextState = SEQ_SYNC;
            else          holdInc   = 1'b1;
          end
        end
        SEQ_SYNC: begin
          if (cycleTick) begin
            nextState = SEQ_RAMP;
            nextStep  = FIRST_STEP;
          end
        end
        SEQ_RAMP: begin
          if (cycleTick) begin
            if (rampStep == LAST_STEP) nextState = SEQ_RUN;
            else                       nextStep  = rampStep + FIRST_STEP;
          end
        end
        SEQ_RUN: begin
          nextState = SEQ_RUN;
        end
        default: nextState = SEQ_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= SEQ_OFF;
      rampStep <= '0;
    end else begin
      state    <= nextState;
      rampStep <= nextStep;
    end
  end

  always_comb begin
    strobe.holdClr  = holdClr;
    strobe.holdInc  = holdInc;
    strobe.rampOn   = (state == SEQ_RAMP);
    strobe.runOn    = (state == SEQ_RUN);
    strobe.rampStep = rampStep;
    syncOn          = (state == SEQ_SYNC) || (state == SEQ_RAMP) || (state == SEQ_RUN);
  end

endmodule

// File: rtl/softstart_timing.sv
module softstart_timing
  import softstart_pkg::*;
#(
  parameter int CNT_W        = 8,
  parameter int DELAY_CYCLES = 56,
  parameter int RAMP_STEPS   = 7
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       oscDischarge,
  input  seqStrobe_t strobe,
  output logic       cycleTick,
  output logic       holdDone,
  output logic       rampGate
);

  localparam int                HOLD_W   = $clog2(DELAY_CYCLES + 1);
  localparam int                RAMP_DIV = RAMP_STEPS + 1;
  localparam int                PROD_W   = CNT_W + STEP_W;
  localparam logic [CNT_W-1:0]  CNT_MAX  = '1;
  localparam logic [HOLD_W-1:0] HOLD_END = HOLD_W'(DELAY_CYCLES);

  logic              disQ;
  logic [CNT_W-1:0]  elapsed;
  logic [CNT_W-1:0]  chargeLen;
  logic [HOLD_W-1:0] holdCnt;
  logic [PROD_W-1:0] scale, product, startPoint;
  logic              pastStart;

  assign cycleTick = oscDischarge & ~disQ;
  assign holdDone  = (holdCnt == HOLD_END);

  // Phase edge detect, charge-length measurement, hold-off counter.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      disQ      <= 1'b0;
      elapsed   <= '0;
      chargeLen <= '0;
      holdCnt   <= '0;
    end else begin
      disQ <= oscDischarge;
      if (cycleTick) chargeLen <= elapsed;
      if (oscDischarge)            elapsed <= '0;
      else if (elapsed != CNT_MAX) elapsed <= elapsed + 1'b1;
      if (strobe.holdClr)      holdCnt <= '0;
      else if (strobe.holdInc) holdCnt <= holdCnt + 1'b1;
    end
  end

  // Leading-edge position: start = L * (DIV - k) / DIV.
  always_comb begin
    scale   = PROD_W'(RAMP_DIV) - PROD_W'(strobe.rampStep);
    product = PROD_W'(chargeLen) * scale;
  end

  generate
    if ((RAMP_DIV & (RAMP_DIV - 1)) == 0) begin : g_shiftDiv
      assign startPoint = product >> $clog2(RAMP_DIV);
    end else begin : g_trueDiv
      assign startPoint = product / PROD_W'(RAMP_DIV);
    end
  endgenerate

  assign pastStart = (PROD_W'(elapsed) >= startPoint);
  assign rampGate  = strobe.runOn | (strobe.rampOn & ~oscDischarge & pastStart);

endmodule

// File: rtl/softstart_seq.sv
module softstart_seq
  import softstart_pkg::*;
#(
  parameter int DELAY_CYCLES = 56,
  parameter int RAMP_STEPS   = 7,
  parameter int CNT_W        = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic oscDischarge,
  input  logic supplyOk,
  input  logic overCurrent,
  output logic syncEnable,
  output logic pulseGate
);

  seqStrobe_t strobe;
  logic       cycleTick, holdDone, rampGate, syncOn, healthy;

  softstart_ctrl #(
    .RAMP_STEPS(RAMP_STEPS)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .supplyOk   (supplyOk),
    .overCurrent(overCurrent),
    .cycleTick  (cycleTick),
    .holdDone   (holdDone),
    .strobe     (strobe),
    .syncOn     (syncOn)
  );

  softstart_timing #(
    .CNT_W       (CNT_W),
    .DELAY_CYCLES(DELAY_CYCLES),
    .RAMP_STEPS  (RAMP_STEPS)
  ) u_timing (
    .clk         (clk),
    .rstN        (rstN),
    .oscDischarge(oscDischarge),
    .strobe      (strobe),
    .cycleTick   (cycleTick),
    .holdDone    (holdDone),
    .rampGate    (rampGate)
  );

  // Faults kill both permissions in the current clock.
  assign healthy    = supplyOk & ~overCurrent;
  assign syncEnable = syncOn & healthy;
  assign pulseGate  = rampGate & healthy;

endmodule

// File: rtl/softstart_checker.sv
module softstart_checker #(
  parameter int DELAY_CYCLES = 56
) (
  input logic clk,
  input logic rstN,
  input logic oscDischarge,
  input logic supplyOk,
  input logic overCurrent,
  input logic syncEnable,
  input logic pulseGate
);

  localparam int Q_W = $clog2(DELAY_CYCLES + 2) + 1;
  localparam logic [Q_W-1:0] Q_MAX = '1;

  logic           disQ;
  logic           tick;
  logic [Q_W-1:0] ticksQuiet;
  logic [1:0]     ticksSync;

  assign tick = oscDischarge & ~disQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      disQ       <= 1'b0;
      ticksQuiet <= '0;
      ticksSync  <= '0;
    end else begin
      disQ <= oscDischarge;
      if (overCurrent || !supplyOk)         ticksQuiet <= '0;
      else if (tick && ticksQuiet != Q_MAX) ticksQuiet <= ticksQuiet + 1'b1;
      if (!syncEnable)                      ticksSync  <= '0;
      else if (tick && ticksSync != 2'd3)   ticksSync  <= ticksSync + 1'b1;
    end
  end

  a_r1_oc_kills_outputs: assert property (@(posedge clk) disable iff (!rstN)
    overCurrent |-> (!syncEnable && !pulseGate));

  a_r2_uv_kills_outputs: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |-> (!syncEnable && !pulseGate));

  a_r3_hold_off_length: assert property (@(posedge clk) disable iff (!rstN)
    $rose(syncEnable) |-> (int'(ticksQuiet) > DELAY_CYCLES));

  a_r4_sync_leads_pulse: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pulseGate) |-> (ticksSync != 2'd0));

  a_r5_gate_needs_sync: assert property (@(posedge clk) disable iff (!rstN)
    pulseGate |-> syncEnable);

endmodule

bind softstart_seq softstart_checker #(.DELAY_CYCLES(DELAY_CYCLES)) u_checker (
  .clk         (clk),
  .rstN        (rstN),
  .oscDischarge(oscDischarge),
  .supplyOk    (supplyOk),
  .overCurrent (overCurrent),
  .syncEnable  (syncEnable),
  .pulseGate   (pulseGate)
);

// File: tb/test_softstart_seq.sv
`timescale 1ns/1ps
module test_softstart_seq;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic oscDis = 1'b0;
  logic supplyOk = 1'b0;
  logic overCurrent = 1'b0;
  logic syncEnable, pulseGate;

  int nChecks = 0;
  int nFail = 0;
  int cycles = 0;
  bit done = 0;

  // oscillator stimulus
  int chCfg = 12;
  int dsCfg = 3;
  int oscPhase = 0;

  // reference model state
  int mState = 0;   // 0 off, 1 hold, 2 sync-only, 3 ramp, 4 run
  int mCnt = 0;
  int mStep = 0;
  int mElapsed = 0;
  int mLen = 0;
  bit mPrev = 0;

  always #2.5 clk = ~clk;

  softstart_seq i_softstart_seq (
    .clk         (clk),
    .rstN        (rstN),
    .oscDischarge(oscDis),
    .supplyOk    (supplyOk),
    .overCurrent (overCurrent),
    .syncEnable  (syncEnable),
    .pulseGate   (pulseGate)
  );

  task automatic finishRun();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  task automatic checkBit(string tag, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s at %0t: actual %0b expected %0b", tag, $time, act, exp);
    end
  endtask

  task automatic checkInt(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  // Oscillator: chCfg clocks of charge, dsCfg clocks of discharge.
  always @(posedge clk) begin
    #1;
    if (oscDis && oscPhase >= dsCfg - 1) begin
      oscDis = 1'b0;
      oscPhase = 0;
    end else if (!oscDis && oscPhase >= chCfg - 1) begin
      oscDis = 1'b1;
      oscPhase = 0;
    end else begin
      oscPhase++;
    end
  end

  // Behavioural reference model, advanced on every rising edge.
  always @(posedge clk) begin
    bit tick;
    if (!rstN) begin
      mState = 0; mCnt = 0; mStep = 0; mElapsed = 0; mLen = 0; mPrev = 0;
    end else begin
      tick = oscDis && !mPrev;
      if (!supplyOk) begin
        mState = 0; mCnt = 0; mStep = 0;
      end else if (overCurrent) begin
        mState = 1; mCnt = 0; mStep = 0;
      end else begin
        case (mState)
          0: begin mState = 1; mCnt = 0; end
          1: if (tick) begin if (mCnt == 56) mState = 2; else mCnt++; end
          2: if (tick) begin mState = 3; mStep = 1; end
          3: if (tick) begin if (mStep == 7) mState = 4; else mStep++; end
          default: ;
        endcase
      end
      if (tick) mLen = mElapsed;
      if (oscDis) mElapsed = 0;
      else if (mElapsed < 255) mElapsed++;
      mPrev = oscDis;
    end
  end

  // Per-clock comparison, away from the active edge.
  always @(negedge clk) begin
    bit okNow, expSync, expGate;
    string tag;
    if (rstN && !done) begin
      okNow   = supplyOk && !overCurrent;
      expSync = okNow && (mState >= 2);
      expGate = okNow && ((mState == 4) ||
                (mState == 3 && !oscDis && mElapsed >= (mLen * (8 - mStep)) / 8));
      if (overCurrent)      tag = "R1";
      else if (!supplyOk)   tag = "R2";
      else if (mState == 1) tag = "R3";
      else if (mState == 2) tag = "R4";
      else if (mState == 3) tag = "R5 R7";
      else                  tag = "R6";
      checkBit({tag, " syncEnable"}, syncEnable, expSync);
      checkBit({tag, " pulseGate"}, pulseGate, expGate);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      nFail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finishRun();
    end
  end

  task automatic driveAfterEdge(ref logic sig, input logic val);
    @(posedge clk);
    #2;
    sig = val;
  endtask

  task automatic waitMidCharge();
    do begin
      @(posedge clk);
      #2;
    end while (!(oscDis == 1'b0 && oscPhase == 1));
  endtask

  // Counts phase boundaries from a fault release through hold-off, sync lead and ramp.
  task automatic runSequenceCheck(string holdTag);
    int rises = 0;
    int guard = 0;
    int lows = 0;
    logic prev = oscDis;
    while (guard < 20000) begin
      @(negedge clk); guard++;
      if (syncEnable) begin prev = oscDis; break; end
      if (oscDis && !prev) rises++;
      prev = oscDis;
    end
    checkInt({holdTag, " boundaries before sync"}, rises, 57);
    rises = 0;
    while (guard < 20000) begin
      @(negedge clk); guard++;
      if (pulseGate) begin prev = oscDis; break; end
      if (oscDis && !prev) rises++;
      prev = oscDis;
    end
    checkInt("R4 boundaries from sync to first pulse", rises, 1);
    while (guard < 20000) begin
      @(negedge clk); guard++;
      if (pulseGate && oscDis) break;
      if (oscDis && !prev) rises++;
      prev = oscDis;
    end
    checkInt("R6 boundaries from sync to full width", rises, 8);
    repeat (40) begin
      @(negedge clk);
      if (!pulseGate) lows++;
    end
    checkInt("R6 gate lows in run", lows, 0);
  endtask

  initial begin
    repeat (6) @(negedge clk);
    checkBit("R8 reset syncEnable", syncEnable, 1'b0);
    checkBit("R8 reset pulseGate", pulseGate, 1'b0);
    driveAfterEdge(rstN, 1'b1);
    @(negedge clk);
    checkBit("R8 after reset pulseGate", pulseGate, 1'b0);
    repeat (30) @(negedge clk);
    checkBit("R2 supply low syncEnable", syncEnable, 1'b0);

    // Power-good start.
    waitMidCharge();
    supplyOk = 1'b1;
    runSequenceCheck("R3");

    // Single-clock overcurrent in run.
    waitMidCharge();
    overCurrent = 1'b1;
    @(negedge clk);
    checkBit("R1 immediate syncEnable", syncEnable, 1'b0);
    checkBit("R1 immediate pulseGate", pulseGate, 1'b0);
    driveAfterEdge(overCurrent, 1'b0);
    repeat (250) @(negedge clk);
    // Overcurrent again during the hold-off.
    waitMidCharge();
    overCurrent = 1'b1;
    driveAfterEdge(overCurrent, 1'b0);
    runSequenceCheck("R9");

    // Longer charge, supply dip during ramp.
    chCfg = 20; dsCfg = 2;
    waitMidCharge();
    overCurrent = 1'b1;
    driveAfterEdge(overCurrent, 1'b0);
    while (!syncEnable) @(negedge clk);
    repeat (60) @(negedge clk);
    driveAfterEdge(supplyOk, 1'b0);
    repeat (5) @(negedge clk);
    checkBit("R2 dip syncEnable", syncEnable, 1'b0);
    checkBit("R2 dip pulseGate", pulseGate, 1'b0);
    waitMidCharge();
    supplyOk = 1'b1;
    runSequenceCheck("R2");

    // Fast oscillator.
    chCfg = 5; dsCfg = 1;
    repeat (20) @(negedge clk);
    waitMidCharge();
    overCurrent = 1'b1;
    driveAfterEdge(overCurrent, 1'b0);
    runSequenceCheck("R3");

    repeat (10) @(negedge clk);
    finishRun();
  end

endmodule